// File: doc/BRIEF.md
# Coupling-Fault Injectable Bit RAM

This block is a small one-bit-wide RAM that can carry one deliberate defect at a time. It is meant to be the device under test when a memory test engine is being verified. With the defect switched off it is an ordinary single-port RAM with a one-cycle read latency. A configuration register selects the defect. It holds an enable bit, a four-bit fault class, an aggressor address, a victim address and three polarity bits (`x`, `y`, `z`). With the defect switched on, the RAM changes stored bits or returned read data the way the chosen defect would.

The static classes cover two-cell coupling defects: state coupling, disturb, failed transition write, destructive write, destructive read, incorrect read and deceptive destructive read. The dynamic classes fire only when a write to the victim is directly followed, on the next clock, by a read of the victim. An operation history state machine supplies that pairing. It has three states: `H_IDLE` (no access last cycle), `H_WROTE` (last cycle was a write) and `H_READ` (last cycle was a read). Every cycle it moves to `H_IDLE` when there is no request, to `H_WROTE` on a write and to `H_READ` on a read. It also keeps the address and the data of the last operation. Bit `z` turns a dynamic class into a coupling variant that also needs the aggressor to hold `x`.

Top module: `coupling_fault_ram`

## Requirements
- R1: Reset clears every cell to 0, clears the configuration to disabled, and holds `mem_rvalid` low.
- R2: A write stores `mem_wdata` at `mem_addr`. A read returns the stored bit on `mem_rdata`, with `mem_rvalid` high, one clock after the request. This holds whenever the enable bit is 0 or the class code is 10 to 15. A configuration write takes effect from the next clock.
- R3: Class 0 (state coupling): while the aggressor holds `x` and the victim holds `y`, the victim is set to the complement of `y` on the next clock, with no access needed. This does not happen in a cycle that writes the victim.
- R4: Class 1 (disturb): a read or a write of any value to the aggressor, while the aggressor holds `x` and the victim holds `y`, sets the victim to the complement of `y`. An access to any other address does not.
- R5: Class 2 (failed transition): a write of `y` to a victim that holds the complement of `y` leaves the victim unchanged while the aggressor holds `x`. The same write succeeds when the aggressor does not hold `x`.
- R6: Class 3 (destructive write): a write of `y` to a victim that already holds `y`, while the aggressor holds `x`, leaves the complement of `y` stored. A transition write to the victim is unaffected.
- R7: Class 4 (destructive read): a read of a victim holding `y`, while the aggressor holds `x`, stores the complement of `y` in the victim and returns it.
- R8: Class 5 (incorrect read): a read of a victim holding `y`, while the aggressor holds `x`, returns the complement of `y`. The stored bit is unchanged.
- R9: Class 6 (deceptive read): a read of a victim holding `y`, while the aggressor holds `x`, returns `y` but leaves the complement of `y` stored.
- R10: Classes 7, 8 and 9 act on a read of the victim on the clock directly after a write of `y` to the victim. Class 7 stores and returns the complement of `y`. Class 8 stores the complement of `y` but returns `y`. Class 9 returns the complement of `y` and keeps the stored bit. An idle cycle between the write and the read prevents the effect.
- R11: With `z` = 1, classes 7 to 9 additionally need the aggressor to hold `x`. With `z` = 0 the aggressor is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req | input | 1 | Memory access request |
| mem_we | input | 1 | 1 = write, 0 = read |
| mem_addr | input | ADDR_W | Access address |
| mem_wdata | input | 1 | Write data |
| mem_rdata | output | 1 | Read data, valid with mem_rvalid |
| mem_rvalid | output | 1 | Read data valid, one clock after a read request |
| cfg_we | input | 1 | Load the fault configuration |
| cfg_enable | input | 1 | Fault active |
| cfg_class | input | 4 | Fault class code (0 to 9; others act fault-free) |
| cfg_aggr | input | ADDR_W | Aggressor address |
| cfg_vict | input | ADDR_W | Victim address |
| cfg_x | input | 1 | Aggressor state that arms the fault |
| cfg_y | input | 1 | Victim state or written value that arms the fault |
| cfg_z | input | 1 | Dynamic classes also need the aggressor to hold x |

## Verification
The bench builds the block with `ADDR_W` = 4, a 16-cell array. The aggressor sits at address 3 and the victim at address 9, so every class can be armed with a few directed writes. At this size, bystander addresses, the idle-cycle break between a write and a read, and the out-of-range class codes can all be exercised next to the armed pair. Each class is checked both in its firing condition and, where it matters, in a condition that must leave the data intact.

// File: rtl/cfr_pkg.sv
package cfr_pkg;

    localparam logic [3:0] FC_STATE      = 4'd0;
    localparam logic [3:0] FC_DISTURB    = 4'd1;
    localparam logic [3:0] FC_TRANS      = 4'd2;
    localparam logic [3:0] FC_WR_DESTR   = 4'd3;
    localparam logic [3:0] FC_RD_DESTR   = 4'd4;
    localparam logic [3:0] FC_RD_WRONG   = 4'd5;
    localparam logic [3:0] FC_RD_DECEPT  = 4'd6;
    localparam logic [3:0] FC_DYN_DESTR  = 4'd7;
    localparam logic [3:0] FC_DYN_DECEPT = 4'd8;
    localparam logic [3:0] FC_DYN_WRONG  = 4'd9;

    typedef enum logic [1:0] {
        H_IDLE  = 2'd0,
        H_WROTE = 2'd1,
        H_READ  = 2'd2
    } hist_state_e;

    typedef struct packed {
        logic       enable;
        logic [3:0] fclass;
        logic       x;
        logic       y;
        logic       z;
    } fault_cfg_t;

endpackage

// File: rtl/cfr_cfg_reg.sv
module cfr_cfg_reg
    import cfr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_enable,
    input  logic [3:0]        cfg_class,
    input  logic [ADDR_W-1:0] cfg_aggr,
    input  logic [ADDR_W-1:0] cfg_vict,
    input  logic              cfg_x,
    input  logic              cfg_y,
    input  logic              cfg_z,
    output fault_cfg_t        cfg_q,
    output logic [ADDR_W-1:0] aggr_q,
    output logic [ADDR_W-1:0] vict_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            aggr_q <= '0;
            vict_q <= '0;
        end else if (cfg_we) begin
            cfg_q.enable <= cfg_enable;
            cfg_q.fclass <= cfg_class;
            cfg_q.x      <= cfg_x;
            cfg_q.y      <= cfg_y;
            cfg_q.z      <= cfg_z;
            aggr_q       <= cfg_aggr;
            vict_q       <= cfg_vict;
        end
    end

endmodule

// File: rtl/cfr_history.sv
module cfr_history
    import cfr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_req,
    input  logic              mem_we,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_wdata,
    output hist_state_e       hist_state,
    output logic [ADDR_W-1:0] hist_addr,
    output logic              hist_data
);

    hist_state_e state_q;
    hist_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= H_IDLE;
            hist_addr <= '0;
            hist_data <= 1'b0;
        end else begin
            state_q <= state_d;
            if (mem_req) begin
                hist_addr <= mem_addr;
                hist_data <= mem_wdata;
            end
        end
    end

    // Next-state logic: each state follows the current cycle's access
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            H_IDLE, H_WROTE, H_READ: begin
                if (!mem_req)    state_d = H_IDLE;
                else if (mem_we) state_d = H_WROTE;
                else             state_d = H_READ;
            end
            default: state_d = H_IDLE;
        endcase
    end

    assign hist_state = state_q;

endmodule

// File: rtl/cfr_fault_eval.sv
module cfr_fault_eval
    import cfr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  fault_cfg_t        cfg,
    input  logic [ADDR_W-1:0] aggr,
    input  logic [ADDR_W-1:0] vict,
    input  logic              mem_req,
    input  logic              mem_we,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_wdata,
    input  logic              cur_bit,
    input  logic              aggr_bit,
    input  logic              vict_bit,
    input  hist_state_e       hist_state,
    input  logic [ADDR_W-1:0] hist_addr,
    input  logic              hist_data,
    output logic              store_bit,
    output logic              read_bit,
    output logic              force_vict,
    output logic              force_val
);

    logic rd, wr, hit_v, hit_a, aggr_armed, dyn_pair;

    always_comb begin
        rd         = mem_req && !mem_we;
        wr         = mem_req && mem_we;
        hit_v      = (mem_addr == vict);
        hit_a      = (mem_addr == aggr);
        aggr_armed = (aggr_bit == cfg.x);
        dyn_pair   = rd && hit_v && (hist_state == H_WROTE) &&
                     (hist_addr == vict) && (hist_data == cfg.y) &&
                     (!cfg.z || aggr_armed);

        store_bit  = mem_wdata;
        read_bit   = cur_bit;
        force_vict = 1'b0;
        force_val  = !cfg.y;

        if (cfg.enable) begin
            unique case (cfg.fclass)
                FC_STATE: begin
                    if (aggr_armed && vict_bit == cfg.y && !(wr && hit_v))
                        force_vict = 1'b1;
                end
                FC_DISTURB: begin
                    if (mem_req && hit_a && aggr_armed && vict_bit == cfg.y)
                        force_vict = 1'b1;
                end
                FC_TRANS: begin
                    if (wr && hit_v && aggr_armed && cur_bit != cfg.y &&
                        mem_wdata == cfg.y)
                        store_bit = cur_bit;
                end
                FC_WR_DESTR: begin
                    if (wr && hit_v && aggr_armed && cur_bit == cfg.y &&
                        mem_wdata == cfg.y)
                        store_bit = !cfg.y;
                end
                FC_RD_DESTR: begin
                    if (rd && hit_v && aggr_armed && cur_bit == cfg.y) begin
                        force_vict = 1'b1;
                        read_bit   = !cfg.y;
                    end
                end
                FC_RD_WRONG: begin
                    if (rd && hit_v && aggr_armed && cur_bit == cfg.y)
                        read_bit = !cfg.y;
                end
                FC_RD_DECEPT: begin
                    if (rd && hit_v && aggr_armed && cur_bit == cfg.y)
                        force_vict = 1'b1;
                end
                FC_DYN_DESTR: begin
                    if (dyn_pair) begin
                        force_vict = 1'b1;
                        read_bit   = !cfg.y;
                    end
                end
                FC_DYN_DECEPT: begin
                    if (dyn_pair) force_vict = 1'b1;
                end
                FC_DYN_WRONG: begin
                    if (dyn_pair) read_bit = !cfg.y;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/coupling_fault_ram.sv
module coupling_fault_ram
    import cfr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_req,
    input  logic              mem_we,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_wdata,
    output logic              mem_rdata,
    output logic              mem_rvalid,
    input  logic              cfg_we,
    input  logic              cfg_enable,
    input  logic [3:0]        cfg_class,
    input  logic [ADDR_W-1:0] cfg_aggr,
    input  logic [ADDR_W-1:0] cfg_vict,
    input  logic              cfg_x,
    input  logic              cfg_y,
    input  logic              cfg_z
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0]  mem_q;
    fault_cfg_t        cfg_q;
    logic [ADDR_W-1:0] aggr_q;
    logic [ADDR_W-1:0] vict_q;
    hist_state_e       hist_state;
    logic [ADDR_W-1:0] hist_addr;
    logic              hist_data;
    logic              store_bit;
    logic              read_bit;
    logic              force_vict;
    logic              force_val;

    cfr_cfg_reg #(.ADDR_W(ADDR_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_enable (cfg_enable),
        .cfg_class  (cfg_class),
        .cfg_aggr   (cfg_aggr),
        .cfg_vict   (cfg_vict),
        .cfg_x      (cfg_x),
        .cfg_y      (cfg_y),
        .cfg_z      (cfg_z),
        .cfg_q      (cfg_q),
        .aggr_q     (aggr_q),
        .vict_q     (vict_q)
    );

    cfr_history #(.ADDR_W(ADDR_W)) u_hist (
        .clk        (clk),
        .rst_n      (rst_n),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .hist_state (hist_state),
        .hist_addr  (hist_addr),
        .hist_data  (hist_data)
    );

    cfr_fault_eval #(.ADDR_W(ADDR_W)) u_eval (
        .cfg        (cfg_q),
        .aggr       (aggr_q),
        .vict       (vict_q),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .cur_bit    (mem_q[mem_addr]),
        .aggr_bit   (mem_q[aggr_q]),
        .vict_bit   (mem_q[vict_q]),
        .hist_state (hist_state),
        .hist_addr  (hist_addr),
        .hist_data  (hist_data),
        .store_bit  (store_bit),
        .read_bit   (read_bit),
        .force_vict (force_vict),
        .force_val  (force_val)
    );

    // Array and read port; a victim force is applied after the access write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q      <= '0;
            mem_rdata  <= 1'b0;
            mem_rvalid <= 1'b0;
        end else begin
            if (mem_req && mem_we) mem_q[mem_addr] <= store_bit;
            if (force_vict)        mem_q[vict_q]   <= force_val;
            mem_rvalid <= mem_req && !mem_we;
            if (mem_req && !mem_we) mem_rdata <= read_bit;
        end
    end

endmodule

// File: rtl/cfr_checker.sv
module cfr_checker #(
    parameter int ADDR_W = 6,
    localparam int DEPTH = 1 << ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_wdata,
    input logic              mem_rdata,
    input logic              mem_rvalid,
    input logic [DEPTH-1:0]  mem_q,
    input logic              cfg_en,
    input logic [3:0]        cfg_cls,
    input logic [ADDR_W-1:0] aggr,
    input logic [ADDR_W-1:0] vict,
    input logic              cfg_x,
    input logic              cfg_y
);

    assert_rvalid_on_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> mem_rvalid);

    assert_rvalid_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && !mem_we) |=> !mem_rvalid);

    assert_clean_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && !cfg_en) |=> (mem_rdata == $past(mem_q[mem_addr])));

    assert_clean_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !cfg_en) |=> (mem_q[$past(mem_addr)] == $past(mem_wdata)));

    assert_state_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && cfg_cls == 4'd0 && mem_q[aggr] == cfg_x && mem_q[vict] == cfg_y &&
         !(mem_req && mem_we && mem_addr == vict))
        |=> (mem_q[$past(vict)] == !$past(cfg_y)));

    assert_wrong_read_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && cfg_cls == 4'd5 && mem_req && !mem_we && mem_addr == vict)
        |=> (mem_q[$past(vict)] == $past(mem_q[vict])));

endmodule

bind coupling_fault_ram cfr_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .mem_rvalid (mem_rvalid),
    .mem_q      (mem_q),
    .cfg_en     (cfg_q.enable),
    .cfg_cls    (cfg_q.fclass),
    .aggr       (aggr_q),
    .vict       (vict_q),
    .cfg_x      (cfg_q.x),
    .cfg_y      (cfg_q.y)
);

// File: tb/coupling_fault_ram_tb.sv
module coupling_fault_ram_tb_top;

    localparam int AW = 4;
    localparam int AG = 3;
    localparam int VI = 9;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          mem_req, mem_we, mem_wdata;
    logic [AW-1:0] mem_addr;
    logic          mem_rdata, mem_rvalid;
    logic          cfg_we, cfg_enable, cfg_x, cfg_y, cfg_z;
    logic [3:0]    cfg_class;
    logic [AW-1:0] cfg_aggr, cfg_vict;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    coupling_fault_ram #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
        .cfg_we(cfg_we), .cfg_enable(cfg_enable), .cfg_class(cfg_class),
        .cfg_aggr(cfg_aggr), .cfg_vict(cfg_vict),
        .cfg_x(cfg_x), .cfg_y(cfg_y), .cfg_z(cfg_z)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic op_write(input int a, input logic d);
        @(negedge clk);
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = a[AW-1:0]; mem_wdata = d;
    endtask

    task automatic idle();
        @(negedge clk);
        mem_req = 1'b0; mem_we = 1'b0;
    endtask

    // Read issued at one negedge, result sampled at the next
    task automatic read_check(input int a, input logic exp, input string tag);
        @(negedge clk);
        mem_req = 1'b1; mem_we = 1'b0; mem_addr = a[AW-1:0];
        @(negedge clk);
        checks++;
        if (mem_rvalid !== 1'b1 || mem_rdata !== exp) begin
            errors++;
            $display("FAIL %s: addr %0d actual rvalid=%b data=%b expected rvalid=1 data=%b",
                     tag, a, mem_rvalid, mem_rdata, exp);
        end
        mem_req = 1'b0;
    endtask

    task automatic set_cfg(input logic en, input logic [3:0] cls,
                           input logic x, input logic y, input logic z);
        @(negedge clk);
        mem_req = 1'b0; cfg_we = 1'b1; cfg_enable = en; cfg_class = cls;
        cfg_aggr = AG[AW-1:0]; cfg_vict = VI[AW-1:0]; cfg_x = x; cfg_y = y; cfg_z = z;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic clear_pair();
        set_cfg(1'b0, 4'd0, 1'b0, 1'b0, 1'b0);
        op_write(AG, 1'b0);
        op_write(VI, 1'b0);
        idle();
    endtask

    task automatic t_reset();
        check("R1 rvalid low in reset", mem_rvalid, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        read_check(5, 1'b0, "R1 cleared cell");
        read_check(VI, 1'b0, "R1 cleared victim");
    endtask

    task automatic t_clean();
        op_write(2, 1'b1); op_write(7, 1'b0); op_write(15, 1'b1); idle();
        read_check(2, 1'b1, "R2 plain 2");
        read_check(7, 1'b0, "R2 plain 7");
        read_check(15, 1'b1, "R2 plain 15");
        clear_pair();
        set_cfg(1'b1, 4'd12, 1'b0, 1'b1, 1'b0);
        op_write(VI, 1'b1); op_write(VI, 1'b1);
        read_check(VI, 1'b1, "R2 unknown class");
        read_check(VI, 1'b1, "R2 unknown class reread");
    endtask

    task automatic t_state();
        clear_pair();
        set_cfg(1'b1, 4'd0, 1'b1, 1'b0, 1'b0);
        idle();
        read_check(VI, 1'b0, "R3 aggressor not armed");
        op_write(AG, 1'b1); idle(); idle();
        read_check(VI, 1'b1, "R3 victim forced");
        set_cfg(1'b0, 4'd0, 1'b0, 1'b0, 1'b0);
        read_check(VI, 1'b1, "R3 forced value stored");
    endtask

    task automatic t_disturb();
        clear_pair();
        set_cfg(1'b1, 4'd1, 1'b0, 1'b0, 1'b0);
        op_write(5, 1'b1); idle();
        read_check(VI, 1'b0, "R4 bystander access");
        read_check(AG, 1'b0, "R4 aggressor read");
        read_check(VI, 1'b1, "R4 victim disturbed");
    endtask

    task automatic t_trans();
        clear_pair();
        set_cfg(1'b1, 4'd2, 1'b1, 1'b1, 1'b0);
        op_write(AG, 1'b1); op_write(VI, 1'b1); idle();
        read_check(VI, 1'b0, "R5 transition blocked");
        op_write(AG, 1'b0); op_write(VI, 1'b1); idle();
        read_check(VI, 1'b1, "R5 transition allowed");
    endtask

    task automatic t_wrdest();
        clear_pair();
        set_cfg(1'b1, 4'd3, 1'b0, 1'b1, 1'b0);
        op_write(VI, 1'b1); idle();
        read_check(VI, 1'b1, "R6 transition write intact");
        op_write(VI, 1'b1); idle();
        read_check(VI, 1'b0, "R6 repeat write destroys");
    endtask

    task automatic t_rddest();
        clear_pair();
        set_cfg(1'b1, 4'd4, 1'b1, 1'b0, 1'b0);
        op_write(AG, 1'b1); idle();
        read_check(VI, 1'b1, "R7 destructive read output");
        read_check(VI, 1'b1, "R7 destroyed value stored");
    endtask

    task automatic t_rdwrong();
        clear_pair();
        set_cfg(1'b1, 4'd5, 1'b0, 1'b1, 1'b0);
        op_write(VI, 1'b1); idle();
        read_check(VI, 1'b0, "R8 wrong output");
        read_check(VI, 1'b0, "R8 wrong output again");
        set_cfg(1'b0, 4'd0, 1'b0, 1'b0, 1'b0);
        read_check(VI, 1'b1, "R8 stored value kept");
    endtask

    task automatic t_rddecept();
        clear_pair();
        set_cfg(1'b1, 4'd6, 1'b0, 1'b0, 1'b0);
        read_check(VI, 1'b0, "R9 correct output");
        read_check(VI, 1'b1, "R9 content flipped");
    endtask

    task automatic t_dynamic();
        clear_pair();
        set_cfg(1'b1, 4'd7, 1'b0, 1'b1, 1'b0);
        op_write(VI, 1'b1);
        read_check(VI, 1'b0, "R10 class7 output");
        read_check(VI, 1'b0, "R10 class7 stored");
        op_write(VI, 1'b1); idle();
        read_check(VI, 1'b1, "R10 idle breaks pair");

        clear_pair();
        set_cfg(1'b1, 4'd8, 1'b0, 1'b0, 1'b0);
        op_write(VI, 1'b0);
        read_check(VI, 1'b0, "R10 class8 output");
        read_check(VI, 1'b1, "R10 class8 stored");

        clear_pair();
        set_cfg(1'b1, 4'd9, 1'b0, 1'b1, 1'b0);
        op_write(VI, 1'b1);
        read_check(VI, 1'b0, "R10 class9 output");
        read_check(VI, 1'b1, "R10 class9 stored");
    endtask

    task automatic t_dyn_coupled();
        clear_pair();
        set_cfg(1'b1, 4'd7, 1'b1, 1'b1, 1'b1);
        op_write(VI, 1'b1);
        read_check(VI, 1'b1, "R11 aggressor not armed");
        op_write(AG, 1'b1);
        op_write(VI, 1'b1);
        read_check(VI, 1'b0, "R11 aggressor armed");
    endtask

    initial begin
        rst_n = 1'b0;
        mem_req = 1'b0; mem_we = 1'b0; mem_addr = '0; mem_wdata = 1'b0;
        cfg_we = 1'b0; cfg_enable = 1'b0; cfg_class = '0;
        cfg_aggr = '0; cfg_vict = '0; cfg_x = 1'b0; cfg_y = 1'b0; cfg_z = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        t_clean();
        t_state();
        t_disturb();
        t_trans();
        t_wrdest();
        t_rddest();
        t_rdwrong();
        t_rddecept();
        t_dynamic();
        t_dyn_coupled();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule